// File: doc/BRIEF.md
# Latched Interrupt Status Unit

This block sits next to one channel of a data-mover and turns the channel engine's event lines ("transfer finished" and "transfer aborted") into a software-visible interrupt. It holds four word registers: a read-only view of the live event lines, a latched request register that captures events and that software clears by writing ones, an enable mask, and a read-only detect register that shows the latched requests gated by the mask. The channel's interrupt output is asserted whenever any detected bit is set. Because several channel outputs may be ORed onto one shared line, a channel with nothing detected keeps its output low. A handler can then read the detect register and ignore the interrupt when it reads zero.

An abort also latches the "finished" bit, so the two conditions must be told apart by the abort bit. By default, events latch on the rising edge of their input line, so a line that stays high raises one request only. A parameter selects plain level capture instead.

Top module: `isu_irq_unit`

## Requirements
- R1: After reset, all four registers read zero and the interrupt output is low.
- R2: The status register (byte offset 0x10) reads the live event lines: the done line at bit 1 and the abort line at bit 13. All other bits read zero.
- R3: A rising edge on the done line sets bit 1 of the request register (offset 0x14) at the clock edge where the line is first sampled high.
- R4: A rising edge on the abort line sets both bit 13 and bit 1 of the request register.
- R5: A write to the request register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: When an event and a write-one-to-clear hit the same request bit in the same cycle, the bit ends up set.
- R7: The enable register (offset 0x18) stores only bits 1 and 13. Its other bits, and any address that is not mapped, read zero.
- R8: The detect register (offset 0x1C) reads the request register ANDed with the enable register.
- R9: The interrupt output equals the OR of the detect bits one clock later. It stays low whenever the detect value is zero.
- R10: Writes to the status and detect registers change no register.
- R11: An event line that is held high raises one request only. After that request is cleared, the bit stays clear while the line remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte address of the combinational read |
| rd_data | output | DATA_W | Read data for rd_addr |
| done_evt | input | 1 | Done event line from the channel engine |
| abort_evt | input | 1 | Abort event line from the channel engine |
| irq | output | 1 | Channel interrupt, suitable for ORing onto a shared line |

## Verification
Reads are combinational, so a register value is checked a short settle time after the edge that updated it. A write or an event sampled at edge N shows in the request, enable and detect registers right after N, and the interrupt output follows one edge later, at N+1. The bench drives each stimulus just after a rising edge and samples right after the next edge. It checks the interrupt only after the extra edge has passed. It sweeps every enable pattern against every event combination and works out the expected request, detect and interrupt values arithmetically.

// File: rtl/isu_pkg.sv
package isu_pkg;
   // Byte offsets of the channel interrupt registers
   localparam int OFF_STAT = 'h10;
   localparam int OFF_REQ  = 'h14;
   localparam int OFF_EN   = 'h18;
   localparam int OFF_DET  = 'h1C;
   // Index of each event line inside the event vector
   localparam int EV_DONE  = 0;
   localparam int EV_ABORT = 1;
   localparam int EV_NUM   = 2;
endpackage

// File: rtl/isu_edge_detect.sv
module isu_edge_detect #(
   parameter int N          = 2,
   parameter bit EDGE_LATCH = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] hit
);
   logic [N-1:0] prev;

   for (genvar i = 0; i < N; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev[i] <= 1'b0;
         else        prev[i] <= lvl[i];
      end
      assign hit[i] = EDGE_LATCH ? (lvl[i] & ~prev[i]) : lvl[i];

      // R11: a line held high gives no second hit in edge mode
      a_r11_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
         (EDGE_LATCH && prev[i] && lvl[i]) |-> !hit[i]);
   end
endmodule

// File: rtl/isu_req_latch.sv
module isu_req_latch #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr) | set;
   end

   // R6: every bit set by an event is present one cycle later, clear or not
   a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((q & $past(set)) == $past(set)));

   // R5: bits written as one with no event are gone one cycle later
   a_r5_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr != '0) && (set == '0)) |=> ((q & $past(clr)) == '0));
endmodule

// File: rtl/isu_read_mux.sv
module isu_read_mux
   import isu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] live,
   input  logic [DATA_W-1:0] req,
   input  logic [DATA_W-1:0] en,
   output logic [DATA_W-1:0] rd_data
);
   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         ADDR_W'(OFF_STAT): rd_data = live;
         ADDR_W'(OFF_REQ):  rd_data = req;
         ADDR_W'(OFF_EN):   rd_data = en;
         ADDR_W'(OFF_DET):  rd_data = req & en;
         default:           rd_data = '0;
      endcase
   end
endmodule

// File: rtl/isu_irq_unit.sv
module isu_irq_unit
   import isu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 8,
   parameter int DONE_BIT   = 1,
   parameter int ABORT_BIT  = 13,
   parameter bit EDGE_LATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              done_evt,
   input  logic              abort_evt,
   output logic              irq
);
   localparam logic [DATA_W-1:0] DONE_M  = DATA_W'(1) << DONE_BIT;
   localparam logic [DATA_W-1:0] ABORT_M = DATA_W'(1) << ABORT_BIT;
   localparam logic [DATA_W-1:0] IMPL_M  = DONE_M | ABORT_M;

   if (DONE_BIT >= DATA_W || ABORT_BIT >= DATA_W || DONE_BIT < 0 || ABORT_BIT < 0)
   begin : g_bad_bit
      $error("isu_irq_unit: event bit outside the data word");
   end
   if (DONE_BIT == ABORT_BIT) begin : g_bad_same
      $error("isu_irq_unit: done and abort bits must differ");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("isu_irq_unit: ADDR_W too narrow for the register offsets");
   end

   logic [EV_NUM-1:0] ev_lvl, ev_hit;
   logic [DATA_W-1:0] live, set_v, clr_v, req, en, det;

   assign ev_lvl[EV_DONE]  = done_evt;
   assign ev_lvl[EV_ABORT] = abort_evt;

   isu_edge_detect #(.N(EV_NUM), .EDGE_LATCH(EDGE_LATCH)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(ev_lvl), .hit(ev_hit)
   );

   always_comb begin
      live  = (done_evt ? DONE_M : '0) | (abort_evt ? ABORT_M : '0);
      // an abort reports completion as well
      set_v = ((ev_hit[EV_DONE] | ev_hit[EV_ABORT]) ? DONE_M : '0)
            | (ev_hit[EV_ABORT] ? ABORT_M : '0);
      clr_v = (wr_en && wr_addr == ADDR_W'(OFF_REQ)) ? (wr_data & IMPL_M) : '0;
   end

   isu_req_latch #(.W(DATA_W)) u_req (
      .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .q(req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   en <= '0;
      else if (wr_en && wr_addr == ADDR_W'(OFF_EN)) en <= wr_data & IMPL_M;
   end

   assign det = req & en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |det;
   end

   isu_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .rd_addr(rd_addr), .live(live), .req(req), .en(en), .rd_data(rd_data)
   );

   // R9: a zero detect read-back means no interrupt on the next cycle
   a_r9_quiet_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(OFF_DET) && rd_data == '0) |=> !irq);

   // R7: the enable read-back never shows reserved bits
   a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(OFF_EN)) |-> ((rd_data & ~IMPL_M) == '0));

   // R4: an abort edge latches both the abort and the done bit
   a_r4_abort_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
      (EDGE_LATCH && $rose(abort_evt)) |=> (req[ABORT_BIT] && req[DONE_BIT]));

   // R3: a done edge latches the done bit
   a_r3_done_latches: assert property (@(posedge clk) disable iff (!rst_n)
      (EDGE_LATCH && $rose(done_evt)) |=> req[DONE_BIT]);

   // R10: a write to a read-only register leaves the enable mask unchanged
   a_r10_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == ADDR_W'(OFF_STAT) || wr_addr == ADDR_W'(OFF_DET)))
      |=> $stable(en));
endmodule

// File: tb/isu_irq_unit_bench.sv
module isu_irq_unit_bench;
   localparam int DW = 32;
   localparam int AW = 8;
   localparam logic [DW-1:0] M_DONE  = 32'h0000_0002;
   localparam logic [DW-1:0] M_ABORT = 32'h0000_2000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          done_evt = 1'b0;
   logic          abort_evt = 1'b0;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;
   logic [DW-1:0] m_req = '0;
   logic [DW-1:0] m_en = '0;

   always #10 clk = ~clk;

   isu_irq_unit u_isu_irq_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .done_evt(done_evt), .abort_evt(abort_evt), .irq(irq)
   );

   task automatic check(input string req_id, input logic [DW-1:0] got,
                        input logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", req_id, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
      if (a == 8'h14) m_req = m_req & ~d;
      if (a == 8'h18) m_en = d & (M_DONE | M_ABORT);
   endtask

   task automatic pulse(input logic dn, input logic ab);
      done_evt = dn; abort_evt = ab;
      tick();
      done_evt = 1'b0; abort_evt = 1'b0;
      if (dn | ab) m_req = m_req | M_DONE;
      if (ab) m_req = m_req | M_ABORT;
      tick();
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      logic [DW-1:0] en_pat;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      rd(8'h10, d); check("R1 status", d, '0);
      rd(8'h14, d); check("R1 req", d, '0);
      rd(8'h18, d); check("R1 en", d, '0);
      rd(8'h1C, d); check("R1 det", d, '0);
      check("R1 irq", {31'b0, irq}, '0);

      // R2 live status
      done_evt = 1'b1; rd(8'h10, d); check("R2 done live", d, M_DONE);
      abort_evt = 1'b1; rd(8'h10, d); check("R2 both live", d, M_DONE | M_ABORT);
      done_evt = 1'b0; abort_evt = 1'b0;
      rd(8'h10, d); check("R2 idle live", d, '0);

      // R7 enable stores only implemented bits, unmapped reads zero
      wr(8'h18, 32'hFFFF_FFFF);
      rd(8'h18, d); check("R7 en mask", d, M_DONE | M_ABORT);
      rd(8'h04, d); check("R7 unmapped", d, '0);
      wr(8'h18, 32'h0);
      wr(8'h14, 32'hFFFF_FFFF);
      tick();

      // R3 R4 R8 R9 sweep of enable patterns against event combinations
      for (int e = 0; e < 4; e++) begin
         for (int v = 0; v < 4; v++) begin
            en_pat = (e[0] ? M_DONE : '0) | (e[1] ? M_ABORT : '0);
            wr(8'h18, en_pat);
            wr(8'h14, 32'hFFFF_FFFF);
            tick();
            check("R9 irq idle", {31'b0, irq}, '0);
            pulse(v[0], v[1]);
            rd(8'h14, d); check(v[1] ? "R4 req" : "R3 req", d, m_req);
            rd(8'h1C, d); check("R8 det", d, m_req & m_en);
            check("R9 irq", {31'b0, irq}, {31'b0, |(m_req & m_en)});
         end
      end

      // R5 partial clear
      wr(8'h18, M_DONE | M_ABORT);
      pulse(1'b0, 1'b1);
      wr(8'h14, M_ABORT);
      rd(8'h14, d); check("R5 partial clear", d, M_DONE);
      tick();
      check("R9 irq stays", {31'b0, irq}, 32'h1);

      // R10 writes to read-only registers
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h1C, 32'hFFFF_FFFF);
      rd(8'h14, d); check("R10 req kept", d, M_DONE);
      rd(8'h18, d); check("R10 en kept", d, M_DONE | M_ABORT);
      rd(8'h1C, d); check("R10 det kept", d, M_DONE);

      // R6 event and clear on the same bit in the same cycle
      wr(8'h14, 32'hFFFF_FFFF);
      done_evt = 1'b1; wr_en = 1'b1; wr_addr = 8'h14; wr_data = M_DONE;
      tick();
      wr_en = 1'b0; done_evt = 1'b0;
      rd(8'h14, d); check("R6 event wins", d, M_DONE);

      // R11 held line latches once
      wr(8'h14, 32'hFFFF_FFFF);
      done_evt = 1'b1;
      tick();
      rd(8'h14, d); check("R11 first edge", d, M_DONE);
      wr(8'h14, M_DONE);
      tick(); tick();
      rd(8'h14, d); check("R11 no relatch", d, '0);
      check("R11 irq low", {31'b0, irq}, '0);
      done_evt = 1'b0;
      tick();

      // R9 masked request keeps the line low
      wr(8'h18, M_ABORT);
      pulse(1'b1, 1'b0);
      tick();
      rd(8'h1C, d); check("R9 masked det", d, '0);
      check("R9 masked irq", {31'b0, irq}, '0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule